// File: doc/BRIEF.md
# Interleaved Accumulator Slot Tracker

This block decides when a new 128-bit message block may enter an interleaved multiply-accumulate loop used for one-time-authenticator hashing. The loop keeps several independent partial accumulators (slots) in flight so that a multi-cycle pipeline stays busy. Each accepted block takes the next slot in rotation. A flag register chain runs beside the arithmetic pipeline and presents, after a fixed latency, the slot whose accumulator is being written back.

The tracker holds one busy bit per slot. It lowers its input ready when the slot it would hand out next still has a block in flight, and raises ready again in the very cycle that slot's write-back appears. After reset every slot counts as already written, so the first round of blocks goes in without a stall. A clear input starts a new message. It rewinds the rotation to slot 0 and marks every slot as fresh, meaning that the next block into that slot must start from a zero accumulator. Write-backs already in flight still drain.

Top module: `acc_slot_tracker`

## Requirements
- R1: During reset and in the first cycle after it, in_ready is 1, issue_slot is 0, issue_fresh is 1, wb_valid is 0 and last_wb_slot is LANES-1.
- R2: issue_slot advances by one, wrapping from LANES-1 to 0, after each cycle with in_valid and in_ready both high. In any other cycle without clear_acc it keeps its value.
- R3: After reset, LANES back-to-back blocks are all accepted without a stall.
- R4: in_ready is 0 while the slot shown on issue_slot holds an accepted block whose write-back has not yet appeared. A write-back of any other slot does not change this.
- R5: A block accepted at a clock edge appears as wb_valid=1 with wb_slot equal to its slot exactly LATENCY cycles later. Cycles without an accepted block never produce wb_valid.
- R6: In the cycle in which the write-back of the slot shown on issue_slot is presented, in_ready is already 1 (no clear_acc).
- R7: One cycle after a write-back, last_wb_slot equals that write-back's slot. Without a write-back it holds its value.
- R8: While clear_acc is 1, in_ready is 0. After the clear, issue_slot is 0 and every slot is fresh. In-flight write-backs still appear on schedule.
- R9: issue_fresh is 1 for the first block entering each slot after reset or clear_acc, and 0 for later blocks into that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | The offered block is taken at this edge |
| clear_acc | input | 1 | Start a new message: rewind the rotation, mark all slots fresh |
| issue_slot | output | $clog2(LANES) | Slot given to the block accepted this cycle |
| issue_fresh | output | 1 | The accepted block must start from a zero accumulator |
| wb_valid | output | 1 | A write-back is presented this cycle |
| wb_slot | output | $clog2(LANES) | Slot of the presented write-back |
| last_wb_slot | output | $clog2(LANES) | Slot of the most recent write-back |

## Verification
The bench builds the tracker with eight slots and a pipeline latency of ten. With that latency, back-to-back input runs out of free slots. A two-cycle stall then follows, and ready comes back in the cycle the first write-back arrives, so the stall, the same-cycle release and the wrap of the rotation all appear within a few dozen cycles. Sparse input shows that idle cycles never turn into write-backs. A clear issued with blocks still in flight shows the rewind while older write-backs still drain.

// File: rtl/ast_pkg.sv
// Package: shared helpers for the accumulator slot tracker.
// Assumes: slot counts are small positive integers.
package ast_pkg;

    // Next slot in rotation, wrapping at the lane count.
    function automatic int unsigned ast_wrap_inc(input int unsigned cur, input int unsigned lanes);
        return (cur + 1 >= lanes) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/ast_slot_counter.sv
// Module: rotating slot index.
// What it does: holds the slot handed to the next accepted block and
// advances it on each accept; a clear rewinds it to slot 0.
// Assumes: accept and clear never coincide (the top forces ready low on clear).
module ast_slot_counter #(
    parameter int LANES = 8,
    localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          clear,
    output logic [SW-1:0] slot
);
    import ast_pkg::*;

    logic [SW-1:0] slot_nxt;

    // Wrapped successor of the current slot.
    always_comb slot_nxt = SW'(ast_wrap_inc(int'(slot), LANES));

    // Slot register: reset/clear to 0, step on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)      slot <= '0;
        else if (clear)  slot <= '0;
        else if (accept) slot <= slot_nxt;
    end

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clear) |=>
            slot == (($past(slot) == SW'(LANES-1)) ? '0 : $past(slot) + 1'b1));

    p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !clear) |=> $stable(slot));

endmodule

// File: rtl/ast_wb_shift.sv
// Module: write-back flag chain.
// What it does: carries {valid, slot} for every cycle through LATENCY
// register stages alongside the arithmetic pipeline; empty cycles enter
// with valid cleared. The last stage is the write-back.
// Assumes: LATENCY >= 1.
module ast_wb_shift #(
    parameter int LANES   = 8,
    parameter int LATENCY = 8,
    localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [SW-1:0] push_slot,
    output logic          wb_valid,
    output logic [SW-1:0] wb_slot
);
    logic          st_v [LATENCY];
    logic [SW-1:0] st_s [LATENCY];

    for (genvar g = 0; g < LATENCY; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage: capture the accept flag and its slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_v[0] <= 1'b0;
                    st_s[0] <= '0;
                end else begin
                    st_v[0] <= push;
                    st_s[0] <= push_slot;
                end
            end
        end else begin : g_body
            // Later stage: shift from the stage before.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_v[g] <= 1'b0;
                    st_s[g] <= '0;
                end else begin
                    st_v[g] <= st_v[g-1];
                    st_s[g] <= st_s[g-1];
                end
            end
        end
    end

    assign wb_valid = st_v[LATENCY-1];
    assign wb_slot  = st_s[LATENCY-1];

endmodule

// File: rtl/ast_slot_state.sv
// Module: per-slot busy and fresh bits.
// What it does: a slot turns busy when a block is accepted into it and
// idle when its write-back appears; a slot is fresh from reset or clear
// until its first block is accepted.
// Assumes: accept and clear never coincide.
module ast_slot_state #(
    parameter int LANES = 8,
    localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [SW-1:0]    acc_slot,
    input  logic             clear,
    input  logic             wb_valid,
    input  logic [SW-1:0]    wb_slot,
    output logic [LANES-1:0] busy,
    output logic [LANES-1:0] fresh
);
    logic [LANES-1:0] busy_nxt;

    // Busy update: write-back releases first, accept sets last.
    always_comb begin
        busy_nxt = busy;
        if (wb_valid) busy_nxt[wb_slot]  = 1'b0;
        if (accept)   busy_nxt[acc_slot] = 1'b1;
    end

    // Busy register.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= busy_nxt;
    end

    // Fresh register: all set on reset/clear, bit dropped on accept.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) fresh <= '1;
        else if (accept)     fresh[acc_slot] <= 1'b0;
    end

    p_accept_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clear) |=> busy[$past(acc_slot)] && !fresh[$past(acc_slot)]);

    p_wb_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> busy[wb_slot]);

    p_clear_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (&fresh));

endmodule

// File: rtl/acc_slot_tracker.sv
// Module: interleaved accumulator slot tracker (top).
// What it does: gates input ready on the busy bit of the slot about to be
// reused, with a same-cycle bypass when that slot's write-back is
// presented; tags each block with its slot and fresh flag; records the
// most recent write-back slot.
// Assumes: LANES >= 2, LATENCY >= 1; synchronous active-low reset.
module acc_slot_tracker #(
    parameter int LANES   = 8,
    parameter int LATENCY = 8,
    localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          clear_acc,
    output logic [SW-1:0] issue_slot,
    output logic          issue_fresh,
    output logic          wb_valid,
    output logic [SW-1:0] wb_slot,
    output logic [SW-1:0] last_wb_slot
);
    logic             accept;
    logic [LANES-1:0] busy;
    logic [LANES-1:0] fresh;
    logic             wb_hits_next;

    ast_slot_counter #(.LANES(LANES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .accept(accept), .clear(clear_acc), .slot(issue_slot)
    );

    ast_wb_shift #(.LANES(LANES), .LATENCY(LATENCY)) u_shift (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_slot(issue_slot),
        .wb_valid(wb_valid), .wb_slot(wb_slot)
    );

    ast_slot_state #(.LANES(LANES)) u_state (
        .clk(clk), .rst_n(rst_n), .accept(accept), .acc_slot(issue_slot),
        .clear(clear_acc), .wb_valid(wb_valid), .wb_slot(wb_slot),
        .busy(busy), .fresh(fresh)
    );

    // Write-back of the slot about to be reused releases it this cycle.
    always_comb wb_hits_next = wb_valid && (wb_slot == issue_slot);

    // Ready: no clear, and next slot idle or being released now.
    always_comb in_ready = !clear_acc && (!busy[issue_slot] || wb_hits_next);

    always_comb accept = in_valid && in_ready;

    always_comb issue_fresh = fresh[issue_slot];

    // Record the slot of the most recent write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_wb_slot <= SW'(LANES-1);
        else if (wb_valid) last_wb_slot <= wb_slot;
    end

    p_last_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> last_wb_slot == $past(wb_slot));

    p_clear_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_acc |=> (issue_slot == '0) && issue_fresh);

    p_release_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_hits_next && !clear_acc) |-> in_ready);

endmodule

// File: tb/acc_slot_tracker_test.sv
module acc_slot_tracker_test;
    localparam int LANES = 8;
    localparam int LAT   = 10;
    localparam int SW    = $clog2(LANES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          clear_acc = 1'b0;
    logic          in_ready;
    logic [SW-1:0] issue_slot;
    logic          issue_fresh;
    logic          wb_valid;
    logic [SW-1:0] wb_slot;
    logic [SW-1:0] last_wb_slot;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state
    int  period = 0;
    int  m_idx  = 0;
    int  m_last = LANES - 1;
    bit  m_infl  [LANES];
    int  m_due   [LANES];
    bit  m_fresh [LANES];

    always #5 clk = ~clk;

    acc_slot_tracker #(.LANES(LANES), .LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .clear_acc(clear_acc), .issue_slot(issue_slot), .issue_fresh(issue_fresh),
        .wb_valid(wb_valid), .wb_slot(wb_slot), .last_wb_slot(last_wb_slot)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (period %0d)", tag, what, act, exp, period);
        end
    endtask

    // One cycle: drive at negedge, check outputs against model, advance model at edge.
    task automatic step(input bit v, input bit c, input string tag);
        bit e_ready; bit e_wb; int e_ws; bit acc;
        @(negedge clk);
        in_valid = v; clear_acc = c;
        #1;
        e_wb = 0; e_ws = 0;
        for (int s = 0; s < LANES; s++)
            if (m_infl[s] && m_due[s] == period) begin e_wb = 1; e_ws = s; end
        e_ready = !c && (!m_infl[m_idx] || m_due[m_idx] == period);
        check(tag, "in_ready", int'(in_ready), int'(e_ready));
        check(tag, "issue_slot", int'(issue_slot), m_idx);
        check(tag, "issue_fresh", int'(issue_fresh), int'(m_fresh[m_idx]));
        check(tag, "wb_valid", int'(wb_valid), int'(e_wb));
        if (e_wb) check(tag, "wb_slot", int'(wb_slot), e_ws);
        check(tag, "last_wb_slot", int'(last_wb_slot), m_last);
        acc = v && e_ready;
        @(posedge clk);
        if (e_wb) begin m_infl[e_ws] = 0; m_last = e_ws; end
        if (acc) begin
            m_infl[m_idx] = 1; m_due[m_idx] = period + LAT;
            m_fresh[m_idx] = 0; m_idx = (m_idx + 1) % LANES;
        end
        if (c) begin
            m_idx = 0;
            for (int s = 0; s < LANES; s++) m_fresh[s] = 1;
        end
        period++;
    endtask

    task automatic t_reset();
        rst_n = 0; in_valid = 0; clear_acc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", "in_ready in reset", int'(in_ready), 1);
        check("R1", "last_wb_slot in reset", int'(last_wb_slot), LANES - 1);
        rst_n = 1;
        for (int s = 0; s < LANES; s++) begin m_infl[s] = 0; m_due[s] = 0; m_fresh[s] = 1; end
        m_idx = 0; m_last = LANES - 1; period = 0;
        step(0, 0, "R1");
    endtask

    task automatic t_first_pass();
        for (int i = 0; i < LANES; i++) step(1, 0, "R3_R2_R9");
    endtask

    task automatic t_stall();
        for (int i = 0; i < 12; i++) step(1, 0, "R4_R6_R5");
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 16; i++) step(i % 3 == 0, 0, "R5_R7");
    endtask

    task automatic t_idle();
        for (int i = 0; i < 14; i++) step(0, 0, "R2_R7");
    endtask

    task automatic t_clear();
        for (int i = 0; i < 5; i++) step(1, 0, "R4");
        step(1, 1, "R8");
        for (int i = 0; i < 14; i++) step(1, 0, "R8_R9");
        for (int i = 0; i < 14; i++) step(0, 0, "R5_R7");
    endtask

    initial begin
        t_reset();
        t_first_pass();
        t_stall();
        t_bubbles();
        t_idle();
        t_clear();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule